// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of address translations. Each entry pairs a virtual page number with a physical page number. It also carries the identifier of the address-space context that owns it. A requester presents a virtual page number together with the current context identifier, and learns in the same cycle whether a valid translation exists and what physical page it names. Because ownership is part of the match, entries from several processes live side by side, and moving to another context leaves every stored entry in place.

When a lookup misses, the mapping is obtained elsewhere by a page walk, which is outside this block. The result is then written in through the fill port. A fill whose context and page already match a valid entry refreshes that entry. A new fill goes to the lowest-numbered empty slot. When no slot is empty, it evicts the slot named by a rotating pointer.

Software keeps the store coherent with page-table edits through one invalidation command port. The command can clear every entry, every entry of one context, or the single entry for one context and page. A command takes effect at the next clock edge and overrides a fill presented in the same cycle. The decode of the command is an enumerated operation with four states: `INV_NONE`, `INV_ALL`, `INV_CTX` and `INV_PAGE`. `INV_NONE` is the only state in which a fill is committed. Each other state selects its own clearing action.

Top module: `ctxtlb_top`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the replacement pointer points at entry 0.
- R2: `lk_hit` is 1 in the same cycle, with no clock edge in between, exactly when some valid entry holds both `lk_ctx` and `lk_vpn`. `lk_ppn` then carries that entry's physical page, and carries zero on a miss.
- R3: Changing `lk_ctx` clears nothing. The same virtual page stored under two contexts returns each context's own physical page.
- R4: A committed fill is visible to lookups from the cycle after the clock edge that takes it.
- R5: A fill whose context and page equal those of a valid entry overwrites that entry's physical page and creates no second entry. All other entries keep their contents.
- R6: A fill of a new context and page, while at least one entry is invalid, is written into the lowest-numbered invalid entry.
- R7: A fill of a new context and page, while all entries are valid, replaces the entry named by the replacement pointer. The pointer then advances by one, wrapping from the last entry to entry 0. The pointer moves on no other event.
- R8: `inv_op` is encoded as 2'b00 none, 2'b01 clear all, 2'b10 clear by context, 2'b11 clear one page. Clear all invalidates every entry at the next edge.
- R9: Clear by context invalidates exactly the valid entries whose context equals `inv_ctx`, and leaves all other entries untouched.
- R10: Clear one page invalidates only the entry whose context equals `inv_ctx` and whose page equals `inv_vpn`. If there is no such entry, nothing changes.
- R11: When `inv_op` is not 2'b00, a fill presented in the same cycle is dropped. It writes no entry and does not move the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_ctx | input | 12 | Current context identifier |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_ppn | output | 36 | Physical page of the hit, zero on miss |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 36 | Virtual page of the fill |
| fill_ctx | input | 12 | Context of the fill |
| fill_ppn | input | 36 | Physical page of the fill |
| inv_op | input | 2 | Invalidation command (see R8) |
| inv_ctx | input | 12 | Context for clear-by-context and clear-one-page |
| inv_vpn | input | 36 | Page for clear-one-page |

## Verification
The two functions that can collide in one cycle are a fill and an invalidation command. A correct design must let the command win and leave the fill without effect. The random stimulus presents both together in part of its cycles. Directed cases also pair a fill of a brand-new key with a page clear that matches nothing, so the dropped fill is the only possible change. The outcome is judged at the lookup port against a reference map that applies only the command. The lookup of the fill key must miss, and a later eviction must fall where the unmoved pointer says it should.

// File: rtl/ctxtlb_pkg.sv
package ctxtlb_pkg;

    // Invalidation command decode; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ALL  = 2'b01,
        INV_CTX  = 2'b10,
        INV_PAGE = 2'b11
    } inv_op_e;

endpackage

// File: rtl/ctxtlb_match.sv
module ctxtlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 36,
    parameter int CTX_W = 12,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                ent_valid,
    input  logic [N-1:0][VPN_W-1:0]     ent_vpn,
    input  logic [N-1:0][CTX_W-1:0]     ent_ctx,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [CTX_W-1:0]            key_ctx,
    output logic                        any_hit,
    output logic [IDX_W-1:0]            hit_idx
);

    logic [N-1:0] hit_vec;

    // One comparator per entry: context and page must both agree.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g]
                          && (ent_ctx[g] == key_ctx)
                          && (ent_vpn[g] == key_vpn);
    end

    assign any_hit = |hit_vec;

    // Lowest index wins; with unique keys at most one bit is set anyway.
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // A key never lives in two entries at once.
    AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R5

endmodule

// File: rtl/ctxtlb_victim.sv
module ctxtlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     ent_valid,
    input  logic             alloc,       // committed fill of a new key
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;
    logic             evict;

    assign full  = &ent_valid;
    assign evict = alloc && full;

    // Lowest-numbered invalid entry.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign victim_idx = full ? rr_q : free_idx;

    // Rotating pointer moves only when a valid entry is displaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (evict) begin
            if (rr_q == IDX_W'(N - 1)) rr_q <= '0;
            else                      rr_q <= rr_q + 1'b1;
        end
    end

    AST_FREE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !full) |-> !ent_valid[victim_idx]); // R6

    AST_RR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        evict |=> (rr_q != $past(rr_q))); // R7

    AST_RR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(rr_q)); // R11

endmodule

// File: rtl/ctxtlb_top.sv
module ctxtlb_top
    import ctxtlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 36,
    parameter int PPN_W = 36,
    parameter int CTX_W = 12,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       inv_op,
    input  logic [CTX_W-1:0] inv_ctx,
    input  logic [VPN_W-1:0] inv_vpn
);

    // Entry storage
    logic [N-1:0]            valid_q;
    logic [N-1:0][VPN_W-1:0] vpn_q;
    logic [N-1:0][CTX_W-1:0] ctx_q;
    logic [N-1:0][PPN_W-1:0] ppn_q;

    inv_op_e op;
    assign op = inv_op_e'(inv_op);

    // Lookup, fill and page-invalidate each need their own associative search.
    logic             lk_any,   fl_any,   iv_any;
    logic [IDX_W-1:0] lk_idx,   fl_idx,   iv_idx;

    ctxtlb_match #(.N(N), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_ctx(ctx_q),
        .key_vpn(lk_vpn), .key_ctx(lk_ctx),
        .any_hit(lk_any), .hit_idx(lk_idx)
    );

    ctxtlb_match #(.N(N), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fl_match (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_ctx(ctx_q),
        .key_vpn(fill_vpn), .key_ctx(fill_ctx),
        .any_hit(fl_any), .hit_idx(fl_idx)
    );

    ctxtlb_match #(.N(N), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_iv_match (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_ctx(ctx_q),
        .key_vpn(inv_vpn), .key_ctx(inv_ctx),
        .any_hit(iv_any), .hit_idx(iv_idx)
    );

    // Fill commit and target selection
    logic             fill_commit;
    logic             alloc;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] wr_idx;

    assign fill_commit = fill_en && (op == INV_NONE);
    assign alloc       = fill_commit && !fl_any;
    assign wr_idx      = fl_any ? fl_idx : victim_idx;

    ctxtlb_victim #(.N(N)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(valid_q),
        .alloc(alloc),
        .victim_idx(victim_idx)
    );

    // Per-entry context match for clear-by-context
    logic [N-1:0] ctx_sel;
    for (genvar g = 0; g < N; g++) begin : g_ctx_sel
        assign ctx_sel[g] = (ctx_q[g] == inv_ctx);
    end

    // Valid bits: command decode, one action per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (op)
                INV_ALL:  valid_q <= '0;
                INV_CTX:  valid_q <= valid_q & ~ctx_sel;
                INV_PAGE: if (iv_any) valid_q[iv_idx] <= 1'b0;
                INV_NONE: if (fill_commit) valid_q[wr_idx] <= 1'b1;
                default:  valid_q <= valid_q;
            endcase
        end
    end

    // Payload: written only on a committed fill
    always_ff @(posedge clk) begin
        if (fill_commit) begin
            vpn_q[wr_idx] <= fill_vpn;
            ctx_q[wr_idx] <= fill_ctx;
            ppn_q[wr_idx] <= fill_ppn;
        end
    end

    // Lookup outputs
    always_comb begin
        lk_hit = lk_any;
        lk_ppn = lk_any ? ppn_q[lk_idx] : '0;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_ALL) |=> (valid_q == '0)); // R8

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_commit |=> valid_q[$past(wr_idx)]); // R4

    AST_REFRESH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_commit && fl_any) |=> ($countones(valid_q) == $past($countones(valid_q)))); // R5

    AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_PAGE && iv_any) |=> !valid_q[$past(iv_idx)]); // R10

    AST_CMD_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op != INV_NONE) |=> ($countones(valid_q) <= $past($countones(valid_q)))); // R11

endmodule

// File: tb/sim_ctxtlb_top.sv
`timescale 1ns/1ps
module sim_ctxtlb_top;

    localparam int N = 16;
    localparam int VW = 36;
    localparam int PW = 36;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [CW-1:0] lk_ctx = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic          fill_en = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [CW-1:0] fill_ctx = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic [1:0]    inv_op = 2'b00;
    logic [CW-1:0] inv_ctx = '0;
    logic [VW-1:0] inv_vpn = '0;

    always #4 clk = ~clk;

    ctxtlb_top u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx), .fill_ppn(fill_ppn),
        .inv_op(inv_op), .inv_ctx(inv_ctx), .inv_vpn(inv_vpn)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference map built from the requirements
    bit          m_v   [N];
    logic [VW-1:0] m_vpn [N];
    logic [CW-1:0] m_ctx [N];
    logic [PW-1:0] m_ppn [N];
    int          m_rr;

    function automatic int m_find(logic [VW-1:0] v, logic [CW-1:0] c);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == v && m_ctx[i] == c) return i;
        return -1;
    endfunction

    function automatic void m_apply(bit fe, logic [VW-1:0] fv, logic [CW-1:0] fc,
                                    logic [PW-1:0] fp, logic [1:0] op,
                                    logic [CW-1:0] ic, logic [VW-1:0] iv);
        int idx;
        if (op == 2'b01) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (op == 2'b10) begin
            for (int i = 0; i < N; i++) if (m_ctx[i] == ic) m_v[i] = 1'b0;
        end else if (op == 2'b11) begin
            idx = m_find(iv, ic);
            if (idx >= 0) m_v[idx] = 1'b0;
        end else if (fe) begin
            idx = m_find(fv, fc);
            if (idx < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
                if (idx < 0) begin
                    idx = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
            end
            m_v[idx] = 1'b1; m_vpn[idx] = fv; m_ctx[idx] = fc; m_ppn[idx] = fp;
        end
    endfunction

    // One clock cycle of stimulus; inputs change at the falling edge only.
    task automatic cycle(bit fe, logic [VW-1:0] fv, logic [CW-1:0] fc, logic [PW-1:0] fp,
                         logic [1:0] op, logic [CW-1:0] ic, logic [VW-1:0] iv);
        fill_en = fe; fill_vpn = fv; fill_ctx = fc; fill_ppn = fp;
        inv_op = op; inv_ctx = ic; inv_vpn = iv;
        @(posedge clk);
        m_apply(fe, fv, fc, fp, op, ic, iv);
        @(negedge clk);
        fill_en = 1'b0; inv_op = 2'b00;
    endtask

    task automatic fill(logic [VW-1:0] v, logic [CW-1:0] c, logic [PW-1:0] p);
        cycle(1'b1, v, c, p, 2'b00, '0, '0);
    endtask

    task automatic inval(logic [1:0] op, logic [CW-1:0] c, logic [VW-1:0] v);
        cycle(1'b0, '0, '0, '0, op, c, v);
    endtask

    task automatic check_lk(logic [VW-1:0] v, logic [CW-1:0] c, string req);
        int idx;
        logic          eh;
        logic [PW-1:0] ep;
        lk_vpn = v; lk_ctx = c;
        #1;
        idx = m_find(v, c);
        eh = (idx >= 0);
        ep = eh ? m_ppn[idx] : '0;
        checks++;
        if (lk_hit !== eh || lk_ppn !== ep) begin
            errors++;
            $display("FAIL %s: vpn=%0h ctx=%0h hit=%0b ppn=%0h expected hit=%0b ppn=%0h",
                     req, v, c, lk_hit, lk_ppn, eh, ep);
        end
    endtask

    task automatic sweep(string req);
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 24; v++)
                check_lk(VW'(v), CW'(c), req);
    endtask

    function automatic logic [PW-1:0] rnd_ppn();
        return {$urandom(), $urandom()};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int r;
        void'($urandom(32'd7331));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_vpn[i] = '0; m_ctx[i] = '0; m_ppn[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        check_lk(36'd0, 12'd0, "R1");
        check_lk(36'd5, 12'd1, "R1");

        // R4 / R2: fill visible next cycle, other context misses
        fill(36'd5, 12'd1, 36'hAAAA);
        check_lk(36'd5, 12'd1, "R4");
        check_lk(36'd5, 12'd2, "R2");

        // R3: same page under two contexts
        fill(36'd5, 12'd2, 36'hBBBB);
        check_lk(36'd5, 12'd1, "R3");
        check_lk(36'd5, 12'd2, "R3");

        // R5: refresh of an existing key
        fill(36'd5, 12'd1, 36'hCCCC);
        check_lk(36'd5, 12'd1, "R5");
        check_lk(36'd5, 12'd2, "R5");

        // Fill the remaining 14 slots, then evict in pointer order (R7)
        for (int v = 6; v < 20; v++) fill(VW'(v), 12'd3, rnd_ppn());
        sweep("R6");
        fill(36'd20, 12'd3, 36'h1111);
        check_lk(36'd5, 12'd1, "R7");
        check_lk(36'd20, 12'd3, "R7");
        fill(36'd21, 12'd3, 36'h2222);
        check_lk(36'd5, 12'd2, "R7");
        sweep("R7");

        // R10 then R6: page clear frees one slot, next new fill lands there
        inval(2'b11, 12'd3, 36'd10);
        check_lk(36'd10, 12'd3, "R10");
        check_lk(36'd11, 12'd3, "R10");
        inval(2'b11, 12'd3, 36'd23);
        sweep("R10");
        fill(36'd22, 12'd0, 36'h3333);
        fill(36'd23, 12'd0, 36'h4444);
        sweep("R6");

        // R11: fill collides with a command that matches nothing
        cycle(1'b1, 36'd1, 12'd1, 36'h5555, 2'b11, 12'd2, 36'd0);
        check_lk(36'd1, 12'd1, "R11");
        fill(36'd2, 12'd1, 36'h6666);
        sweep("R11");

        // R9: clear one context
        inval(2'b10, 12'd3, '0);
        sweep("R9");

        // R8: clear all
        fill(36'd4, 12'd2, 36'h7777);
        inval(2'b01, '0, '0);
        sweep("R8");

        // Random mix, keys drawn from a small space to force reuse and eviction
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] op;
            bit fe;
            r = int'($urandom_range(0, 99));
            op = 2'b00;
            if (r < 3)       op = 2'b01;
            else if (r < 8)  op = 2'b10;
            else if (r < 16) op = 2'b11;
            fe = ($urandom_range(0, 99) < 75);
            cycle(fe, VW'($urandom_range(0, 23)), CW'($urandom_range(0, 3)), rnd_ppn(),
                  op, CW'($urandom_range(0, 3)), VW'($urandom_range(0, 23)));
            check_lk(VW'($urandom_range(0, 23)), CW'($urandom_range(0, 3)),
                     (op != 2'b00 && fe) ? "R11" : "R2");
            if (k % 250 == 249) sweep("R3");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule